// File: doc/BRIEF.md
# Calendar Timekeeper Core

The block keeps wall-clock time and calendar date in binary-coded decimal: seconds, minutes, hours (24-hour), day of week, date, month, two-digit year and a century flag. A tick enable, nominally pulsing at 32,768 Hz, feeds a prescaler. The prescaler produces one advance of the time per second and a 512 Hz square wave for checking the oscillator. Software reaches eight byte-wide registers through a simple address/data port with separate read and write strobes.

A stop bit in the seconds register freezes timekeeping. A century-enable bit decides whether the century flag flips when the year wraps. The output pin either carries the test square wave or follows a static level bit in the control register. Reading the seconds register captures every time field at once. Later reads of the other fields return that captured set, so a carry that happens between two reads cannot tear the result. The serial bus front end and battery switchover sit outside the block.

Top module: `rtc_core`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00 and control 80h, and `ftest_out` is 1.
- R2: While running, the time advances by one second once per `TICKS_PER_SEC` cycles with `tick_en` high. Cycles with `tick_en` low do not count. A write to address 0 clears the prescaler, so the first advance lands exactly `TICKS_PER_SEC` ticks after that write.
- R3: Each field counts in BCD. Seconds and minutes go 59 to 00 and carry. Hours go 23 to 00 and carry into the day. Day of week runs 1 to 7 and then returns to 1.
- R4: The date wraps after 30 in months 04, 06, 09 and 11, and after 31 in the other months. In month 02 it wraps after 29 when the BCD year is a multiple of 4, and after 28 otherwise. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R5: When the year wraps, the century flag (address 2 bit 6) inverts if century-enable (address 2 bit 7) is 1. If century-enable is 0, the flag keeps its value.
- R6: While the stop bit (address 0 bit 7) is 1, no time field and no output toggle changes. Rewriting the seconds register with bit 7 at 0 resumes counting, and the next advance comes `TICKS_PER_SEC` ticks later.
- R7: With the test-enable bit (address 7 bit 6) at 1 and the clock running, `ftest_out` inverts every `TICKS_PER_SEC/1024` ticks, which is 512 Hz at 32,768 ticks per second.
- R8: With the test-enable bit at 0, `ftest_out` equals the level bit (address 7 bit 7), so a level bit of 0 drives the pin low.
- R9: `rdata` updates on the clock edge that samples `rd_en` and holds when there is no read. A read of address 0 captures all seven time fields. Reads of addresses 1 to 6 return the captured values. A read of address 7 returns the live control byte.
- R10: When a write lands on the same edge as a one-second advance, the written field takes the written value and the other fields advance. A write to address 0 on that edge cancels the advance.
- R11: Register layout, with unused bits reading 0: address 0 holds {stop, seconds[6:0]}; address 1 minutes[6:0]; address 2 {century-enable, century, hours[5:0]}; address 3 day[2:0]; address 4 date[5:0]; address 5 month[4:0]; address 6 year[7:0]; address 7 {level, test-enable, 6'b0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Oscillator tick enable, one per 32,768 Hz period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address 0 to 7 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| ftest_out | output | 1 | Frequency-test / level output pin |

## Verification
Two situations can share one edge. A register write can land on the edge that advances the second, and a seconds read can land on the edge where a carry ripples through every field. After a seconds write the prescaler phase is known exactly, so the bench places a minutes write, a seconds write and a seconds read on that exact edge. For the writes it checks that the written field wins while the other fields advance, or that nothing advances when the seconds register itself is written. For the read it checks that the captured minutes match the captured seconds before the carry, and that the next seconds read shows the carried values.

// File: rtl/rtc_pkg.sv
// Shared types and BCD helpers for the timekeeper core.
// Assumes all time fields hold valid BCD when written by software.
package rtc_pkg;

    typedef struct packed {
        logic       stop;
        logic [6:0] sec;
        logic [6:0] min;
        logic       ceb;
        logic       cb;
        logic [5:0] hr;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] yr;
    } rtc_time_t;

    localparam logic [2:0] REG_SEC  = 3'd0;
    localparam logic [2:0] REG_MIN  = 3'd1;
    localparam logic [2:0] REG_HR   = 3'd2;
    localparam logic [2:0] REG_DOW  = 3'd3;
    localparam logic [2:0] REG_DATE = 3'd4;
    localparam logic [2:0] REG_MON  = 3'd5;
    localparam logic [2:0] REG_YR   = 3'd6;
    localparam logic [2:0] REG_CTL  = 3'd7;

    localparam rtc_time_t TIME_RST = '{stop: 1'b0, sec: 7'h00, min: 7'h00,
                                       ceb: 1'b0, cb: 1'b0, hr: 6'h00,
                                       dow: 3'd1, date: 6'h01, mon: 5'h01,
                                       yr: 8'h00};

    // Two-digit BCD increment (no wrap handling; caller decides wrap).
    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // BCD year divisible by four: even tens with 0/4/8, odd tens with 2/6.
    function automatic logic is_leap(input logic [7:0] yr);
        if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        else       return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    endfunction

    // Last valid date of a month, in BCD.
    function automatic logic [5:0] last_date(input logic [4:0] mon, input logic [7:0] yr);
        case (mon)
            5'h02:                      return is_leap(yr) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    // Byte image of one time register; unused bits read zero.
    function automatic logic [7:0] time_byte(input rtc_time_t t, input logic [2:0] a);
        case (a)
            REG_SEC:  return {t.stop, t.sec};
            REG_MIN:  return {1'b0, t.min};
            REG_HR:   return {t.ceb, t.cb, t.hr};
            REG_DOW:  return {5'b0, t.dow};
            REG_DATE: return {2'b0, t.date};
            REG_MON:  return {3'b0, t.mon};
            REG_YR:   return t.yr;
            default:  return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the oscillator tick enable into a one-second pulse and a
// 1/1024-second toggling square wave. Holds both counters while run is low;
// restart clears both counters and suppresses the pulse in that cycle.
// Assumes TICKS_PER_SEC is a multiple of 1024 for an exact 512 Hz output.
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic run,
    input  logic restart,
    output logic sec_pulse,
    output logic sq_out
);
    localparam int HALF = (TICKS_PER_SEC >= 1024) ? TICKS_PER_SEC / 1024 : 1;
    localparam int CW   = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic [HW-1:0] hcnt;
    logic          adv;
    logic          sec_wrap;
    logic          half_wrap;

    assign adv       = tick_en && run && !restart;
    assign sec_wrap  = (cnt == CW'(TICKS_PER_SEC - 1));
    assign half_wrap = (hcnt == HW'(HALF - 1));
    assign sec_pulse = adv && sec_wrap;

    // Second counter: counts qualified ticks, wraps once per second.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (adv)          cnt <= sec_wrap ? '0 : cnt + 1'b1;
    end

    // Half-period counter and square wave for the test output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt   <= '0;
            sq_out <= 1'b0;
        end else if (restart) begin
            hcnt   <= '0;
        end else if (adv) begin
            hcnt <= half_wrap ? '0 : hcnt + 1'b1;
            if (half_wrap) sq_out <= ~sq_out;
        end
    end
endmodule

// File: rtl/rtc_timebase.sv
// Time and calendar register file. Advances all BCD fields by one second on
// sec_pulse and applies software writes afterwards, so a written field wins
// over the advance in the same cycle. Also holds the two control bits.
// Assumes sec_pulse is already suppressed when the seconds register is written.
module rtc_timebase
    import rtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sec_pulse,
    input  logic            wr_en,
    input  logic [2:0]      addr,
    input  logic [7:0]      wdata,
    output rtc_time_t       cur,
    output logic            ctl_level,
    output logic            ctl_test
);
    rtc_time_t  nxt;
    logic [7:0] inc_sec, inc_min, inc_hr, inc_date, inc_mon, inc_yr;

    assign inc_sec  = bcd_next({1'b0, cur.sec});
    assign inc_min  = bcd_next({1'b0, cur.min});
    assign inc_hr   = bcd_next({2'b0, cur.hr});
    assign inc_date = bcd_next({2'b0, cur.date});
    assign inc_mon  = bcd_next({3'b0, cur.mon});
    assign inc_yr   = bcd_next(cur.yr);

    // Next-state: carry chain from seconds to century, then write override.
    always_comb begin
        nxt = cur;
        if (sec_pulse) begin
            if (cur.sec != 7'h59) nxt.sec = inc_sec[6:0];
            else begin
                nxt.sec = 7'h00;
                if (cur.min != 7'h59) nxt.min = inc_min[6:0];
                else begin
                    nxt.min = 7'h00;
                    if (cur.hr != 6'h23) nxt.hr = inc_hr[5:0];
                    else begin
                        nxt.hr  = 6'h00;
                        nxt.dow = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
                        if (cur.date != last_date(cur.mon, cur.yr)) nxt.date = inc_date[5:0];
                        else begin
                            nxt.date = 6'h01;
                            if (cur.mon != 5'h12) nxt.mon = inc_mon[4:0];
                            else begin
                                nxt.mon = 5'h01;
                                if (cur.yr != 8'h99) nxt.yr = inc_yr;
                                else begin
                                    nxt.yr = 8'h00;
                                    if (cur.ceb) nxt.cb = ~cur.cb;
                                end
                            end
                        end
                    end
                end
            end
        end
        if (wr_en) begin
            case (addr)
                REG_SEC:  begin nxt.stop = wdata[7]; nxt.sec = wdata[6:0]; end
                REG_MIN:  nxt.min  = wdata[6:0];
                REG_HR:   begin nxt.ceb = wdata[7]; nxt.cb = wdata[6]; nxt.hr = wdata[5:0]; end
                REG_DOW:  nxt.dow  = wdata[2:0];
                REG_DATE: nxt.date = wdata[5:0];
                REG_MON:  nxt.mon  = wdata[4:0];
                REG_YR:   nxt.yr   = wdata;
                default:  ;
            endcase
        end
    end

    // Time register update.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= TIME_RST;
        else        cur <= nxt;
    end

    // Control bits: level defaults high, test output off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_level <= 1'b1;
            ctl_test  <= 1'b0;
        end else if (wr_en && addr == REG_CTL) begin
            ctl_level <= wdata[7];
            ctl_test  <= wdata[6];
        end
    end
endmodule

// File: rtl/rtc_readport.sv
// Registered read path with a coherent snapshot. A seconds read copies all
// time fields into a shadow; other time addresses read the shadow, the
// control address reads live. Assumes software reads seconds first.
module rtc_readport
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  rtc_time_t  cur,
    input  logic [7:0] ctl_byte,
    output logic [7:0] rdata
);
    rtc_time_t shadow;

    // Snapshot capture and read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= TIME_RST;
            rdata  <= 8'h00;
        end else if (rd_en) begin
            if (addr == REG_SEC) begin
                shadow <= cur;
                rdata  <= time_byte(cur, REG_SEC);
            end else if (addr == REG_CTL) begin
                rdata  <= ctl_byte;
            end else begin
                rdata  <= time_byte(shadow, addr);
            end
        end
    end
endmodule

// File: rtl/rtc_core.sv
// Timekeeper core top: prescaler, time/calendar register file, snapshot read
// port and the output pin select. Assumes tick_en is a single-cycle enable
// synchronous to clk at the oscillator rate.
module rtc_core
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       ftest_out
);
    rtc_time_t live_q;
    logic      sec_pulse;
    logic      sq;
    logic      restart;
    logic      ctl_level;
    logic      ctl_test;

    assign restart = wr_en && (addr == REG_SEC);

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .run       (!live_q.stop),
        .restart   (restart),
        .sec_pulse (sec_pulse),
        .sq_out    (sq)
    );

    rtc_timebase u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_pulse (sec_pulse),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .cur       (live_q),
        .ctl_level (ctl_level),
        .ctl_test  (ctl_test)
    );

    rtc_readport u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .addr     (addr),
        .cur      (live_q),
        .ctl_byte ({ctl_level, ctl_test, 6'b0}),
        .rdata    (rdata)
    );

    // Output pin: square wave in test mode, otherwise the static level bit.
    assign ftest_out = ctl_test ? sq : ctl_level;
endmodule

// File: rtl/rtc_core_chk.sv
// Temporal checks on the timekeeper core, bound to every rtc_core instance.
module rtc_core_chk
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rdata,
    input logic       ftest_out,
    input logic       ctl_test,
    input rtc_time_t  live
);
    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live.stop && !wr_en) |=> $stable(live));

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_en) |=> $stable(live));

    // R3
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live.sec[3:0] <= 4'd9 && live.sec[6:4] <= 3'd5 && !wr_en)
        |=> (live.sec[3:0] <= 4'd9 && live.sec[6:4] <= 3'd5));

    // R5
    century_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!live.ceb && !wr_en) |=> $stable(live.cb));

    // R7
    test_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_test && !tick_en && !wr_en) |=> $stable(ftest_out));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind rtc_core rtc_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .ftest_out (ftest_out),
    .ctl_test  (ctl_test),
    .live      (live_q)
);

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
    localparam int TPS = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ftest_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // expected time model, binary
    int es, em, eh, edw, edt, emo, ey, ecb, eceb;

    always #4 clk = ~clk;

    rtc_core #(.TICKS_PER_SEC(TPS)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ftest_out(ftest_out)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic void next_second();
        es++;
        if (es == 60) begin
            es = 0; em++;
            if (em == 60) begin
                em = 0; eh++;
                if (eh == 24) begin
                    eh = 0;
                    edw = (edw == 7) ? 1 : edw + 1;
                    edt++;
                    if (edt > dim(emo, ey)) begin
                        edt = 1; emo++;
                        if (emo == 13) begin
                            emo = 1; ey++;
                            if (ey == 100) begin
                                ey = 0;
                                if (eceb != 0) ecb = 1 - ecb;
                            end
                        end
                    end
                end
            end
        end
    endfunction

    function automatic logic [7:0] exp_byte(input int a);
        case (a)
            0: return to_bcd(es);
            1: return to_bcd(em);
            2: return {eceb[0], ecb[0], 6'b0} | to_bcd(eh);
            3: return to_bcd(edw);
            4: return to_bcd(edt);
            5: return to_bcd(emo);
            default: return to_bcd(ey);
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic set_time(input int s, input int m, input int h, input int dw,
                            input int dt, input int mo, input int y,
                            input int ceb, input int cb);
        es = s; em = m; eh = h; edw = dw; edt = dt; emo = mo; ey = y;
        eceb = ceb; ecb = cb;
        wr(3'd0, 8'h80);
        wr(3'd1, to_bcd(m));
        wr(3'd2, exp_byte(2));
        wr(3'd3, to_bcd(dw));
        wr(3'd4, to_bcd(dt));
        wr(3'd5, to_bcd(mo));
        wr(3'd6, to_bcd(y));
        wr(3'd0, to_bcd(s));
    endtask

    task automatic check_all(input string tag);
        logic [7:0] d;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            chk(tag, d, exp_byte(a));
        end
    endtask

    task automatic adv_check(input string tag, input int s, input int m, input int h,
                             input int dw, input int dt, input int mo, input int y,
                             input int ceb, input int cb);
        set_time(s, m, h, dw, dt, mo, y, ceb, cb);
        repeat (TPS) @(negedge clk);
        next_second();
        check_all(tag);
    endtask

    initial begin
        logic [7:0] d;
        logic       ft0;
        int         toggles, consec;
        logic       prev, last_chg;
        int unsigned seed;
        seed = $urandom(32'd7331);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 ftest_out", {7'b0, ftest_out}, 8'h01);
        rd(3'd0, d); chk("R1 sec", d, 8'h00);
        rd(3'd1, d); chk("R1 min", d, 8'h00);
        rd(3'd2, d); chk("R1 hr", d, 8'h00);
        rd(3'd3, d); chk("R1 dow", d, 8'h01);
        rd(3'd4, d); chk("R1 date", d, 8'h01);
        rd(3'd5, d); chk("R1 mon", d, 8'h01);
        rd(3'd6, d); chk("R1 yr", d, 8'h00);
        rd(3'd7, d); chk("R1 ctl", d, 8'h80);

        // R11 unused bits read zero (stopped so nothing advances)
        wr(3'd0, 8'h80);
        wr(3'd3, 8'hFF); rd(3'd0, d); rd(3'd3, d); chk("R11 dow mask", d, 8'h07);
        wr(3'd4, 8'hFF); rd(3'd0, d); rd(3'd4, d); chk("R11 date mask", d, 8'h3F);
        wr(3'd5, 8'hFF); rd(3'd0, d); rd(3'd5, d); chk("R11 mon mask", d, 8'h1F);
        wr(3'd7, 8'hFF); rd(3'd7, d); chk("R11 ctl mask", d, 8'hC0);
        wr(3'd7, 8'h80);

        // R2 exact advance after seconds write
        set_time(10, 0, 0, 1, 1, 1, 0, 0, 0);
        repeat (TPS - 1) @(negedge clk);
        rd(3'd0, d); chk("R2 before second", d, 8'h10);
        rd(3'd0, d); chk("R2 after second", d, 8'h11);

        // R2 idle ticks are not counted
        set_time(20, 0, 0, 1, 1, 1, 0, 0, 0);
        repeat (10) @(negedge clk);
        tick_en = 1'b0;
        repeat (100) @(negedge clk);
        tick_en = 1'b1;
        repeat (TPS - 11) @(negedge clk);
        rd(3'd0, d); chk("R2 gap before", d, 8'h20);
        rd(3'd0, d); chk("R2 gap after", d, 8'h21);

        // R3 / R4 / R5 directed rollovers
        adv_check("R3 minute carry", 59, 12, 5, 3, 10, 6, 40, 0, 0);
        adv_check("R3 day carry dow7", 59, 59, 23, 7, 10, 6, 40, 0, 0);
        adv_check("R4 feb28 leap", 59, 59, 23, 2, 28, 2, 24, 0, 0);
        adv_check("R4 feb29 leap", 59, 59, 23, 3, 29, 2, 24, 0, 0);
        adv_check("R4 feb28 common", 59, 59, 23, 4, 28, 2, 23, 0, 0);
        adv_check("R4 apr30", 59, 59, 23, 5, 30, 4, 11, 0, 0);
        adv_check("R4 nov30", 59, 59, 23, 5, 30, 11, 11, 0, 0);
        adv_check("R4 jan31", 59, 59, 23, 6, 31, 1, 11, 0, 0);
        adv_check("R4 dec31", 59, 59, 23, 6, 31, 12, 37, 0, 0);
        adv_check("R5 century toggle", 59, 59, 23, 1, 31, 12, 99, 1, 0);
        adv_check("R5 century toggle back", 59, 59, 23, 1, 31, 12, 99, 1, 1);
        adv_check("R5 century frozen", 59, 59, 23, 1, 31, 12, 99, 0, 1);

        // R3 / R4 constrained random times
        for (int i = 0; i < 24; i++) begin
            int s, m, h, dw, dt, mo, y, cbv, cev;
            mo  = 1 + int'($urandom % 12);
            y   = int'($urandom % 100);
            dt  = ($urandom % 2) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y));
            s   = ($urandom % 4 != 0) ? 59 : int'($urandom % 60);
            m   = ($urandom % 2) ? 59 : int'($urandom % 60);
            h   = ($urandom % 2) ? 23 : int'($urandom % 24);
            dw  = 1 + int'($urandom % 7);
            cev = int'($urandom % 2);
            cbv = int'($urandom % 2);
            adv_check("R4 random", s, m, h, dw, dt, mo, y, cev, cbv);
        end

        // R6 stop bit freezes time and test output
        wr(3'd7, 8'h40);
        wr(3'd0, 8'hB0);
        ft0 = ftest_out;
        repeat (3 * TPS) @(negedge clk);
        chk("R6 output frozen", {7'b0, ftest_out}, {7'b0, ft0});
        rd(3'd0, d); chk("R6 stopped sec", d, 8'hB0);
        wr(3'd0, 8'h30);
        repeat (TPS - 1) @(negedge clk);
        rd(3'd0, d); chk("R6 resume before", d, 8'h30);
        rd(3'd0, d); chk("R6 resume after", d, 8'h31);

        // R7 test square wave: toggle every TPS/1024 = 2 ticks
        toggles = 0; consec = 0; prev = ftest_out; last_chg = 1'b0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (ftest_out != prev) begin
                toggles++;
                if (last_chg) consec++;
                last_chg = 1'b1;
            end else last_chg = 1'b0;
            prev = ftest_out;
        end
        chk("R7 toggle count", 8'(toggles), 8'd32);
        chk("R7 toggle spacing", 8'(consec), 8'd0);

        // R8 static level output
        wr(3'd7, 8'h00);
        chk("R8 level low", {7'b0, ftest_out}, 8'h00);
        wr(3'd7, 8'h80);
        chk("R8 level high", {7'b0, ftest_out}, 8'h01);

        // R9 coherent snapshot across a carry on the same edge
        set_time(59, 34, 12, 3, 15, 6, 24, 0, 0);
        repeat (TPS - 1) @(negedge clk);
        rd(3'd0, d); chk("R9 snap sec", d, 8'h59);
        rd(3'd1, d); chk("R9 snap min", d, 8'h34);
        rd(3'd2, d); chk("R9 snap hr", d, 8'h12);
        rd(3'd7, d); chk("R9 live ctl", d, 8'h80);
        rd(3'd0, d); chk("R9 new sec", d, 8'h00);
        rd(3'd1, d); chk("R9 new min", d, 8'h35);

        // R10 minutes write on the advance edge
        set_time(59, 20, 10, 2, 5, 5, 30, 0, 0);
        repeat (TPS - 1) @(negedge clk);
        wr(3'd1, 8'h45);
        next_second();
        em = 45;
        check_all("R10 write wins");

        // R10 seconds write on the advance edge cancels it
        set_time(9, 8, 7, 2, 5, 5, 30, 0, 0);
        repeat (TPS - 1) @(negedge clk);
        wr(3'd0, 8'h30);
        rd(3'd0, d); chk("R10 sec written", d, 8'h30);
        rd(3'd1, d); chk("R10 no carry", d, 8'h08);
        repeat (TPS - 3) @(negedge clk);
        rd(3'd0, d); chk("R10 restart before", d, 8'h30);
        rd(3'd0, d); chk("R10 restart after", d, 8'h31);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule